// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns characters into asynchronous serial frames on one output line. Each frame holds a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The host writes a character into a one-entry holding register. The holding register passes the character to the shifter on a bit boundary. That boundary is either a tick while the shifter is idle, or the tick that ends the last stop bit of the frame in flight. A queued character therefore leaves with no idle time after the previous frame.

Bit timing is not generated here. A one-cycle `bit_tick` pulse from an outside rate divider marks each bit boundary, and every line transition happens in the cycle after a tick. The data length, parity mode and stop count come from static configuration inputs. They are captured when a frame starts and apply to that whole frame. The block reports whether the holding register can take a character, pulses when the line goes idle after a frame, and flags a write that arrives while the holding register is full.

Top module: `sfx_tx`

## Requirements
- R1: Each frame opens with one low start bit. The data bits follow it, least significant bit first.
- R2: `cfg_len` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, and 4 to 7 give 9 bits. Data bits above the selected length are not sent.
- R3: `cfg_par[1]` set enables a parity bit, and `cfg_par[0]` set selects odd parity. Even parity is the XOR of the sent data bits and odd parity is its inverse. The parity bit is sent after the last data bit and before the stop bits.
- R4: `cfg_two_stop` low ends a frame with one high stop bit; high ends it with two.
- R5: Every bit lasts exactly one tick interval. The line changes only in the cycle after a clock edge that sampled `bit_tick` high. A frame starts on the first tick at which the shifter is idle and the holding register is full.
- R6: If the holding register is full at the tick that ends the final stop bit, the next start bit begins at once, with no idle bit.
- R7: A write (`wr_valid` high) while the holding register is full is dropped, and `wr_err` is high for the following cycle only.
- R8: `buf_empty` is high exactly while the holding register can accept a character. It falls in the cycle after an accepted write and rises in the cycle after the tick that moves the character into the shifter.
- R9: `tx_done` is a one-cycle pulse in the cycle after the tick that ends a frame's final stop bit, when no character is queued at that tick.
- R10: With no frame in progress the line is high. After reset, `txd` and `buf_empty` are high and `tx_done` and `wr_err` are low.
- R11: The configuration is captured when a frame starts. Changes to it during that frame do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-boundary pulse |
| cfg_len | input | 3 | Data length code |
| cfg_par | input | 2 | Parity enable (bit 1) and odd select (bit 0) |
| cfg_two_stop | input | 1 | Two stop bits when high |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Pulse when the line goes idle after a frame |
| wr_err | output | 1 | Pulse after a write dropped because the register was full |

## Verification
The bench uses the default build: a 9-bit data path, a minimum length of 5 and a 3-bit length code. With these, every length from 5 to 9 can be selected, and codes 4 to 7 all map to 9 bits. Because the data path is the full 9 bits wide, the bench can set high bits above a short length and confirm they are never sent. A tick every third clock lets back-to-back frames, writes to a full register and configuration changes in the middle of a frame all occur within a few dozen cycles.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  localparam int unsigned SFX_DATA_W  = 9;
  localparam int unsigned SFX_MIN_LEN = 5;
  localparam int unsigned SFX_LEN_W   = 3;

  typedef struct packed {
    logic [SFX_LEN_W-1:0] len_code;
    logic                 par_en;
    logic                 par_odd;
    logic                 two_stop;
  } sfx_cfg_t;

  // Number of data bits for a length code, capped at the data width.
  function automatic int unsigned sfx_len(input int unsigned code,
                                          input int unsigned min_len,
                                          input int unsigned max_len);
    int unsigned l;
    l = min_len + code;
    if (l > max_len) l = max_len;
    return l;
  endfunction

  // XOR of the low `len` bits, inverted for odd parity.
  function automatic logic sfx_parity(input logic [SFX_DATA_W-1:0] d,
                                      input int unsigned len,
                                      input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < int'(SFX_DATA_W); i++)
      if (i < int'(len)) p = p ^ d[i];
    return p;
  endfunction

  // Total line bits of a frame: start + data + parity + stops.
  function automatic int unsigned sfx_frame_bits(input int unsigned len,
                                                 input logic par_en,
                                                 input logic two_stop);
    return 1 + len + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
  endfunction

endpackage

// File: rtl/sfx_hold_buf.sv
module sfx_hold_buf #(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          wr_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data   <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= wr_valid && full;
      if (wr_valid && !full) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sfx_frame_fmt.sv
module sfx_frame_fmt
  import sfx_pkg::*;
#(
  parameter int unsigned DW      = 9,
  parameter int unsigned MIN_LEN = 5,
  parameter int unsigned FW      = 13,
  parameter int unsigned CW      = 4
) (
  input  logic [DW-1:0] data,
  input  sfx_cfg_t      cfg,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] nbits
);

  int unsigned len;
  logic        par;

  always_comb begin
    len   = sfx_len(int'(cfg.len_code), MIN_LEN, DW);
    par   = sfx_parity(SFX_DATA_W'(data), len, cfg.par_odd);
    nbits = CW'(sfx_frame_bits(len, cfg.par_en, cfg.two_stop));
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < int'(DW); i++)
      if (i < int'(len)) frame[i+1] = data[i];
    for (int k = 1; k < int'(FW); k++)
      if (cfg.par_en && k == int'(len) + 1) frame[k] = par;
  end

endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter #(
  parameter int unsigned FW = 13,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          hold_full,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] nbits,
  output logic          txd,
  output logic          busy,
  output logic          load_evt,
  output logic          end_evt,
  output logic          tx_done
);

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          last_bit;

  always_comb begin
    last_bit = busy && (cnt == CW'(1));
    end_evt  = bit_tick && last_bit;
    load_evt = bit_tick && hold_full && (!busy || last_bit);
    txd      = busy ? sh[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      cnt     <= '0;
      busy    <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= end_evt && !hold_full;
      if (load_evt) begin
        sh   <= frame;
        cnt  <= nbits;
        busy <= 1'b1;
      end else if (end_evt) begin
        busy <= 1'b0;
      end else if (busy && bit_tick) begin
        sh  <= {1'b1, sh[FW-1:1]};
        cnt <= cnt - CW'(1);
      end
    end
  end

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int unsigned DATA_W  = SFX_DATA_W,
  parameter int unsigned MIN_LEN = SFX_MIN_LEN,
  parameter int unsigned LEN_W   = SFX_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_two_stop,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done,
  output logic              wr_err
);

  localparam int unsigned FW = 1 + DATA_W + 1 + 2;
  localparam int unsigned CW = $clog2(FW + 1);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              load_evt;
  logic              end_evt;
  logic              sh_busy;
  logic [FW-1:0]     frame;
  logic [CW-1:0]     nbits;
  sfx_cfg_t          cfg;

  always_comb begin
    cfg.len_code = SFX_LEN_W'(cfg_len);
    cfg.par_en   = cfg_par[1];
    cfg.par_odd  = cfg_par[0];
    cfg.two_stop = cfg_two_stop;
  end

  sfx_hold_buf #(.DW(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (load_evt),
    .full     (hold_full),
    .data     (hold_data),
    .wr_err   (wr_err)
  );

  sfx_frame_fmt #(.DW(DATA_W), .MIN_LEN(MIN_LEN), .FW(FW), .CW(CW)) u_fmt (
    .data  (hold_data),
    .cfg   (cfg),
    .frame (frame),
    .nbits (nbits)
  );

  sfx_shifter #(.FW(FW), .CW(CW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .hold_full (hold_full),
    .frame     (frame),
    .nbits     (nbits),
    .txd       (txd),
    .busy      (sh_busy),
    .load_evt  (load_evt),
    .end_evt   (end_evt),
    .tx_done   (tx_done)
  );

  assign buf_empty = !hold_full;

endmodule

// File: rtl/sfx_tx_checker.sv
module sfx_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_valid,
  input logic txd,
  input logic buf_empty,
  input logic tx_done,
  input logic wr_err,
  input logic busy,
  input logic load_evt,
  input logic end_evt
);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !txd);

  assert_line_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  assert_full_write_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !buf_empty |=> wr_err);

  assert_accept_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && buf_empty |=> !buf_empty);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !busy);

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_end_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt && !load_evt |=> txd);

endmodule

bind sfx_tx sfx_tx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .wr_valid  (wr_valid),
  .txd       (txd),
  .buf_empty (buf_empty),
  .tx_done   (tx_done),
  .wr_err    (wr_err),
  .busy      (sh_busy),
  .load_evt  (load_evt),
  .end_evt   (end_evt)
);

// File: tb/sfx_tx_test.sv
`timescale 1ns/1ps
module sfx_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_two_stop = 1'b0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       txd, buf_empty, tx_done, wr_err;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  int done_cnt = 0;

  always #4 clk = ~clk;

  sfx_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .wr_valid(wr_valid),
    .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty),
    .tx_done(tx_done), .wr_err(wr_err)
  );

  // Reference model state
  bit       m_full = 0;
  bit [8:0] m_data = 0;
  bit       m_busy = 0;
  bit       m_bits[$];
  bit       m_done = 0;
  bit       m_err = 0;

  function automatic int len_for(input bit [2:0] code);
    case (code)
      3'd0: return 5;
      3'd1: return 6;
      3'd2: return 7;
      3'd3: return 8;
      default: return 9;
    endcase
  endfunction

  task automatic build_frame(input bit [8:0] d);
    int n;
    bit p;
    n = len_for(cfg_len);
    m_bits.delete();
    m_bits.push_back(1'b0);
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      m_bits.push_back(d[i]);
      p ^= d[i];
    end
    if (cfg_par[1]) m_bits.push_back(p ^ cfg_par[0]);
    m_bits.push_back(1'b1);
    if (cfg_two_stop) m_bits.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    bit was_full, ended;
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_done = 0; m_err = 0; m_bits.delete();
    end else begin
      was_full = m_full;
      ended = 0;
      m_err = wr_valid && was_full;
      m_done = 0;
      if (bit_tick) begin
        if (m_busy) begin
          void'(m_bits.pop_front());
          if (m_bits.size() == 0) begin
            m_busy = 0;
            ended = 1;
          end
        end
        if (!m_busy && was_full) begin
          build_frame(m_data);
          m_busy = 1;
          m_full = 0;
        end else if (ended) begin
          m_done = 1;
        end
      end
      if (wr_valid && !was_full) begin
        m_full = 1;
        m_data = wr_data;
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_tag, "txd", txd, m_busy ? m_bits[0] : 1);
      check("R8", "buf_empty", buf_empty, !m_full);
      check("R9", "tx_done", tx_done, m_done);
      check("R7", "wr_err", wr_err, m_err);
      if (tx_done) done_cnt++;
    end
  end

  // Bit tick every third clock.
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    bit_tick <= (tick_div == 0);
  end

  task automatic send(input bit [8:0] d);
    while (!buf_empty) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (m_busy || m_full) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset txd", txd, 1);
    check("R10", "reset buf_empty", buf_empty, 1);
    check("R10", "reset tx_done", tx_done, 0);
    check("R10", "reset wr_err", wr_err, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R10", "idle line", txd, 1);

    cur_tag = "R1"; cfg_len = 3'd3; cfg_par = 2'b00; cfg_two_stop = 0;
    send(9'h0A5);
    drain();

    cur_tag = "R2"; cfg_len = 3'd0; send(9'h1FF); drain();
    cfg_len = 3'd2; send(9'h155); drain();
    cfg_len = 3'd6; send(9'h1A3); drain();

    cur_tag = "R3"; cfg_len = 3'd3; cfg_par = 2'b10; send(9'h0B7); drain();
    cfg_par = 2'b11; send(9'h0B7); drain();
    cfg_len = 3'd1; cfg_par = 2'b10; send(9'h02C); drain();

    cur_tag = "R4"; cfg_par = 2'b11; cfg_two_stop = 1; cfg_len = 3'd4; send(9'h133); drain();
    cfg_par = 2'b00; send(9'h000); drain();

    cur_tag = "R9"; cfg_two_stop = 0; cfg_len = 3'd3;
    done_cnt = 0; send(9'h081); drain();
    check("R9", "done pulses single frame", done_cnt, 1);

    cur_tag = "R6"; done_cnt = 0;
    send(9'h011); send(9'h022); send(9'h033);
    drain();
    check("R6", "done pulses back-to-back", done_cnt, 1);

    cur_tag = "R7";
    send(9'h044); send(9'h055);
    wr_valid = 1'b1; wr_data = 9'h0EE;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R7", "dropped write flag", wr_err, 1);
    check("R7", "buffer still full", buf_empty, 0);
    drain();

    cur_tag = "R11"; cfg_len = 3'd3; cfg_par = 2'b10; cfg_two_stop = 1;
    send(9'h0C3);
    while (!m_busy) @(negedge clk);
    repeat (5) @(negedge clk);
    cfg_len = 3'd0; cfg_par = 2'b00; cfg_two_stop = 0;
    drain();

    cur_tag = "R5"; cfg_len = 3'd4; cfg_par = 2'b11;
    send(9'h0F0);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule